// File: doc/BRIEF.md
# FIFO ECC Error Statistics Unit

This unit sits beside the three message FIFOs of a CAN controller: the high-priority transmit FIFO, the normal transmit FIFO and the receive FIFO. Each FIFO's ECC checker reports a single-bit (corrected) strobe and a double-bit (uncorrectable) strobe once per cycle. The unit keeps a saturating 16-bit count of each event class per FIFO. Both counts for a FIFO share one 32-bit word. It also keeps six sticky status flags that can raise an interrupt.

Software polls the counter words through a simple register bus. It clears a FIFO's counters by writing a pulse bit to a configuration register. It acknowledges status flags with a write-one-to-clear register. An enable register picks which flags drive the interrupt line. Reads are combinational from the address. Writes take effect at the next rising clock edge.

Top module: `fifo_ecc_stats`

## Requirements
- R1: Source index 0 is the high-priority transmit FIFO, 1 is the normal transmit FIFO and 2 is the receive FIFO. Their counter words read at 0xCC, 0xD0 and 0xD4. Bits [15:0] hold the single-bit count and bits [31:16] hold the double-bit count. Each cycle with a strobe adds one to the matching count, and the new value is visible after the next rising edge.
- R2: Each 16-bit count stops at 0xFFFF and never wraps to zero, however many further strobes arrive.
- R3: A write to 0xC8 with bit i set clears both counts of source i (bit 0 high-priority TX, bit 1 normal TX, bit 2 receive). Counts of sources whose bit is 0 are left alone. The register reads as zero.
- R4: When a clear write and a strobe hit the same counter in one cycle, the counter becomes zero.
- R5: The status register at 0x1C holds sticky flags. Bit 18+2i is the single-bit flag of source i and bit 19+2i is its double-bit flag. A flag sets on any strobe of its class, including when the count is already saturated. All other bits read zero.
- R6: Writing ones to 0x24 at flag positions clears those flags and leaves the others unchanged. If a flag's clear and a new strobe fall in the same cycle, the flag stays set.
- R7: The enable register at 0x20 stores bits [23:18] of the written data and reads them back at the same positions. The output irq is high exactly when some flag is both set and enabled.
- R8: While rst is high, and after it, all counts, flags and enables are zero and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| err_sgl | input | 3 | Per-source single-bit ECC strobe |
| err_dbl | input | 3 | Per-source double-bit ECC strobe |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq | output | 1 | Interrupt, OR of enabled set flags |

## Verification
Two pairs of functions can meet in the same cycle: a counter-clear write with an error strobe on that source, and a flag-clear write with a new strobe on that flag. The bench raises the strobe in the same cycle as the write in both cases. A behavioural model decides the outcome: reset wins for counters, and set wins for flags. The bench compares the read data and irq against that model on every cycle. It also holds strobes long enough to saturate counts. It then clears the flags and strobes again, to show that the flags still set when the counts cannot move.

// File: rtl/ecc_stat_pkg.sv
package ecc_stat_pkg;
    localparam int NUM_SRC  = 3;
    localparam int CNT_W    = 16;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;
    localparam int NUM_FLAG = 2 * NUM_SRC;
    localparam int FLAG_LSB = 18;

    localparam logic [ADDR_W-1:0] ADR_CFG    = 8'hC8;
    localparam logic [ADDR_W-1:0] ADR_CNT0   = 8'hCC;
    localparam logic [ADDR_W-1:0] ADR_STATUS = 8'h1C;
    localparam logic [ADDR_W-1:0] ADR_ENABLE = 8'h20;
    localparam logic [ADDR_W-1:0] ADR_ACK    = 8'h24;

    typedef enum logic [1:0] {
        SRC_TX_HIPRI = 2'd0,
        SRC_TX_NORM  = 2'd1,
        SRC_RX       = 2'd2
    } ecc_src_e;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } reg_req_t;

    function automatic logic [ADDR_W-1:0] cnt_addr(input int src);
        return ADR_CNT0 + ADDR_W'(4 * src);
    endfunction
endpackage

// File: rtl/ecc_sat_counter.sv
module ecc_sat_counter #(
    parameter int W = ecc_stat_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc && (cnt != TOP)) begin
            cnt <= cnt + W'(1);
        end
    end

    a_r2_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (cnt == TOP && !clr) |=> (cnt == TOP));
    a_r4_clear_wins: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));
    a_r1_step: assert property (@(posedge clk) disable iff (rst)
        (!clr && inc && cnt != TOP) |=> (cnt == $past(cnt) + W'(1)));
endmodule

// File: rtl/ecc_src_counters.sv
module ecc_src_counters #(
    parameter int W = ecc_stat_pkg::CNT_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clr,
    input  logic           sgl,
    input  logic           dbl,
    output logic [2*W-1:0] word
);
    logic [W-1:0] sgl_cnt;
    logic [W-1:0] dbl_cnt;

    ecc_sat_counter #(.W(W)) u_sgl (
        .clk(clk), .rst(rst), .clr(clr), .inc(sgl), .cnt(sgl_cnt)
    );
    ecc_sat_counter #(.W(W)) u_dbl (
        .clk(clk), .rst(rst), .clr(clr), .inc(dbl), .cnt(dbl_cnt)
    );

    assign word = {dbl_cnt, sgl_cnt};
endmodule

// File: rtl/ecc_flag_ctrl.sv
module ecc_flag_ctrl #(
    parameter int N = ecc_stat_pkg::NUM_FLAG
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] ack,
    input  logic         en_we,
    input  logic [N-1:0] en_d,
    output logic [N-1:0] status,
    output logic [N-1:0] enable,
    output logic         irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            enable <= '0;
        end else begin
            status <= (status & ~ack) | set;
            if (en_we) begin
                enable <= en_d;
            end
        end
    end

    assign irq = |(status & enable);

    a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
        (|set) |=> ((status & $past(set)) == $past(set)));
    a_r6_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (|(ack & ~set)) |=> ((status & $past(ack & ~set)) == '0));
    a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
        (ack == '0) |=> ((status & $past(status)) == $past(status)));
    a_r8_reset_clean: assert property (@(posedge clk)
        rst |=> (status == '0 && enable == '0 && !irq));
endmodule

// File: rtl/fifo_ecc_stats.sv
module fifo_ecc_stats
    import ecc_stat_pkg::*;
#(
    parameter int N_SRC = ecc_stat_pkg::NUM_SRC,
    parameter int CW    = ecc_stat_pkg::CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  err_sgl,
    input  logic [N_SRC-1:0]  err_dbl,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    localparam int NF = 2 * N_SRC;
    localparam int HALF = DATA_W / 2;

    reg_req_t          req;
    logic [N_SRC-1:0]  cnt_clr;
    logic [2*CW-1:0]   words [N_SRC];
    logic [NF-1:0]     flag_set;
    logic [NF-1:0]     flag_ack;
    logic [NF-1:0]     flag_status;
    logic [NF-1:0]     flag_enable;
    logic              en_we;

    assign req = '{we: reg_we, addr: reg_addr, wdata: reg_wdata};

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        assign cnt_clr[i]      = req.we && (req.addr == ADR_CFG) && req.wdata[i];
        assign flag_set[2*i]   = err_sgl[i];
        assign flag_set[2*i+1] = err_dbl[i];

        ecc_src_counters #(.W(CW)) u_cnt (
            .clk  (clk),
            .rst  (rst),
            .clr  (cnt_clr[i]),
            .sgl  (err_sgl[i]),
            .dbl  (err_dbl[i]),
            .word (words[i])
        );
    end

    assign flag_ack = (req.we && req.addr == ADR_ACK) ? req.wdata[FLAG_LSB +: NF] : '0;
    assign en_we    = req.we && (req.addr == ADR_ENABLE);

    ecc_flag_ctrl #(.N(NF)) u_flags (
        .clk    (clk),
        .rst    (rst),
        .set    (flag_set),
        .ack    (flag_ack),
        .en_we  (en_we),
        .en_d   (req.wdata[FLAG_LSB +: NF]),
        .status (flag_status),
        .enable (flag_enable),
        .irq    (irq)
    );

    always_comb begin
        reg_rdata = '0;
        if (req.addr == ADR_STATUS) begin
            reg_rdata[FLAG_LSB +: NF] = flag_status;
        end else if (req.addr == ADR_ENABLE) begin
            reg_rdata[FLAG_LSB +: NF] = flag_enable;
        end else begin
            for (int i = 0; i < N_SRC; i++) begin
                if (req.addr == cnt_addr(i)) begin
                    reg_rdata = {HALF'(words[i][2*CW-1:CW]), HALF'(words[i][CW-1:0])};
                end
            end
        end
    end

    a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flag_status != '0 && flag_enable != '0));
    a_r3_cfg_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (req.addr == ADR_CFG) |-> (reg_rdata == '0));
endmodule

// File: tb/fifo_ecc_stats_tb.sv
module fifo_ecc_stats_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MAXC = 65535;
    localparam int WATCHDOG = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  err_sgl = '0;
    logic [2:0]  err_dbl = '0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int fails = 0;
    bit started = 0;
    bit done = 0;

    int m_sgl [3];
    int m_dbl [3];
    bit [5:0] m_stat;
    bit [5:0] m_en;

    always #(CLK_PERIOD/2) clk = ~clk;

    fifo_ecc_stats u_dut (
        .clk(clk), .rst(rst), .err_sgl(err_sgl), .err_dbl(err_dbl),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    // Behavioural reference model, updated at the same edge as the design
    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            for (int i = 0; i < 3; i++) begin m_sgl[i] = 0; m_dbl[i] = 0; end
            m_stat = '0;
            m_en = '0;
        end else begin
            for (int i = 0; i < 3; i++) begin
                if (reg_we && reg_addr == 8'hC8 && reg_wdata[i]) begin
                    m_sgl[i] = 0;
                    m_dbl[i] = 0;
                end else begin
                    if (err_sgl[i] && m_sgl[i] < MAXC) m_sgl[i] = m_sgl[i] + 1;
                    if (err_dbl[i] && m_dbl[i] < MAXC) m_dbl[i] = m_dbl[i] + 1;
                end
            end
            if (reg_we && reg_addr == 8'h24) m_stat = m_stat & ~reg_wdata[23:18];
            for (int i = 0; i < 3; i++) begin
                if (err_sgl[i]) m_stat[2*i] = 1'b1;
                if (err_dbl[i]) m_stat[2*i+1] = 1'b1;
            end
            if (reg_we && reg_addr == 8'h20) m_en = reg_wdata[23:18];
        end
    end

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        case (a)
            8'hCC: return {16'(m_dbl[0]), 16'(m_sgl[0])};
            8'hD0: return {16'(m_dbl[1]), 16'(m_sgl[1])};
            8'hD4: return {16'(m_dbl[2]), 16'(m_sgl[2])};
            8'h1C: return {8'h00, m_stat, 18'h0};
            8'h20: return {8'h00, m_en, 18'h0};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'hCC, 8'hD0, 8'hD4: return "R1/R2 counter";
            8'hC8: return "R3 config";
            8'h1C: return "R5 status";
            8'h20: return "R7 enable";
            default: return "R8 unmapped";
        endcase
    endfunction

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            logic [31:0] e;
            logic ei;
            e = exp_rd(reg_addr);
            ei = |(m_stat & m_en);
            checks++;
            if (reg_rdata !== e) begin
                fails++;
                $display("FAIL %s addr=%h actual=%h expected=%h", tag_of(reg_addr), reg_addr, reg_rdata, e);
            end
            checks++;
            if (irq !== ei) begin
                fails++;
                $display("FAIL R7 irq actual=%b expected=%b", irq, ei);
            end
        end
    end

    task automatic apply(input logic we, input logic [7:0] a, input logic [31:0] d,
                         input logic [2:0] s, input logic [2:0] db);
        reg_we = we; reg_addr = a; reg_wdata = d; err_sgl = s; err_dbl = db;
        @(posedge clk); #2;
        reg_we = 1'b0; err_sgl = '0; err_dbl = '0;
    endtask

    task automatic peek_all();
        apply(1'b0, 8'hCC, 0, 0, 0);
        apply(1'b0, 8'hD0, 0, 0, 0);
        apply(1'b0, 8'hD4, 0, 0, 0);
        apply(1'b0, 8'h1C, 0, 0, 0);
        apply(1'b0, 8'h20, 0, 0, 0);
        apply(1'b0, 8'hC8, 0, 0, 0);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > WATCHDOG) begin
                fails++;
                $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, WATCHDOG);
                done = 1;
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        // R8: reset state, strobes held during reset must not count
        err_sgl = 3'b111; err_dbl = 3'b111;
        repeat (3) @(posedge clk);
        #2;
        err_sgl = '0; err_dbl = '0;
        rst = 1'b0;
        peek_all();

        // R1: distinct strobe patterns per source and class
        for (int k = 0; k < 5; k++) apply(1'b0, 8'hCC, 0, 3'b001, 3'b000);
        for (int k = 0; k < 3; k++) apply(1'b0, 8'hD0, 0, 3'b110, 3'b011);
        apply(1'b0, 8'hD4, 0, 3'b000, 3'b100);
        peek_all();

        // R7: enable read-back and irq gating; stray bits outside [23:18] ignored
        apply(1'b1, 8'h20, 32'hFF_03_FF_FF, 0, 0);
        apply(1'b0, 8'h20, 0, 0, 0);
        apply(1'b1, 8'h20, 32'h0000_0000, 0, 0);
        apply(1'b0, 8'h1C, 0, 0, 0);
        apply(1'b1, 8'h20, 32'h0080_0000, 0, 0);

        // R6: clear some flags, others stay; then clear with simultaneous strobe
        apply(1'b1, 8'h24, 32'h0014_0000, 0, 0);
        apply(1'b0, 8'h1C, 0, 0, 0);
        apply(1'b1, 8'h24, 32'h00FC_0000, 3'b001, 3'b000);
        apply(1'b0, 8'h1C, 0, 0, 0);
        apply(1'b1, 8'h24, 32'h00FC_0000, 0, 0);
        apply(1'b0, 8'h1C, 0, 0, 0);

        // R3: clear only the normal TX source; others untouched
        apply(1'b1, 8'hC8, 32'h0000_0002, 0, 0);
        peek_all();
        // R4: clear of source 0 with strobe in the same cycle
        apply(1'b1, 8'hC8, 32'h0000_0001, 3'b001, 3'b001);
        peek_all();

        // R2: saturation of high-priority TX single and receive double counts
        for (int k = 0; k < MAXC + 5; k++) apply(1'b0, 8'hCC, 0, 3'b001, 3'b100);
        peek_all();
        // R5: flags still set on strobes after saturation
        apply(1'b1, 8'h20, 32'h00FC_0000, 0, 0);
        apply(1'b1, 8'h24, 32'h00FC_0000, 0, 0);
        apply(1'b0, 8'h1C, 0, 0, 0);
        apply(1'b0, 8'h1C, 0, 3'b001, 3'b100);
        peek_all();
        // R3: clear all sources together
        apply(1'b1, 8'hC8, 32'h0000_0007, 0, 0);
        peek_all();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule